// File: doc/BRIEF.md
# Floating-Point Pipeline Issue Controller

This block decides when an instruction may enter a three-stage floating-point pipeline. It then tracks each instruction's progress through the stages. It models only occupancy and stalls: it carries a tag for each instruction and no operands, results or exceptions. An upstream sequencer offers one instruction at a time with a valid flag, a two-bit kind and a tag. The block answers combinationally with a ready flag. Each finished instruction is reported downstream as a one-cycle valid pulse that carries its tag.

Three structural limits shape the throughput:
- After three simple instructions issue on back-to-back cycles, the block forces one idle cycle.
- A double-precision multiply, including the fused multiply-add, occupies the middle stage for two cycles, and the stages behind it wait.
- A divide takes the whole unit for a fixed number of cycles. It is admitted only when every stage is empty, and nothing else is admitted while it runs.

Top module: `fp_issue_ctrl`

## Requirements
- R1: After reset, `done_valid` is low and `in_ready` is high for a simple instruction.
- R2: The kind codes are 2'b00 for simple, 2'b01 for double-precision multiply, 2'b10 for divide, and 2'b11, which behaves as simple. A simple instruction accepted in cycle c, with nothing ahead of it stalled, raises `done_valid` with its tag in cycle c+3.
- R3: Every accepted instruction produces exactly one `done_valid` pulse, one cycle long. Tags come out in acceptance order.
- R4: After simple instructions are accepted in three consecutive cycles, `in_ready` is low in the following cycle.
- R5: Any cycle without an acceptance restarts the count of consecutive simple acceptances. So do the acceptance of a double-precision multiply and the acceptance of a divide.
- R6: A double-precision multiply stays two cycles in the middle stage. An unblocked one finishes 4 cycles after acceptance, and back-to-back multiplies finish no more than once every two cycles.
- R7: A divide is accepted only in a cycle where all three stages are empty. `in_ready` depends combinationally on `in_kind`.
- R8: A divide accepted in cycle c raises `done_valid` in cycle c+DIV_CYCLES, and `in_ready` stays low from c+1 through c+DIV_CYCLES-1.
- R9: No instruction is accepted while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_kind | input | 2 | Instruction kind code |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_ready | output | 1 | The offered instruction can enter this cycle |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TAG_W | Tag of the completing instruction |

## Verification
The bound checker checks four rules on every cycle:
- `in_ready` is low while the burst counter is at its limit.
- `in_ready` is low while a divide holds the unit.
- A divide is never admitted while a stage is occupied.
- A middle-stage hold, and the cycle right after a divide is admitted, never produce a completion.

Some behaviours need whole instruction sequences and only the bench's scenarios can show them: exact latencies, the number of wait cycles before each acceptance, the spacing between back-to-back multiplies, the restart of the burst count after a gap, and in-order delivery of every tag exactly once.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  localparam logic [1:0] KIND_SIMPLE = 2'b00;
  localparam logic [1:0] KIND_DPMUL  = 2'b01;
  localparam logic [1:0] KIND_DIV    = 2'b10;

  function automatic logic kind_is_div(input logic [1:0] k);
    return k == KIND_DIV;
  endfunction

  function automatic logic kind_is_dp(input logic [1:0] k);
    return k == KIND_DPMUL;
  endfunction

  // Only single-cycle kinds add to the back-to-back burst count.
  function automatic logic kind_in_burst(input logic [1:0] k);
    return !kind_is_div(k) && !kind_is_dp(k);
  endfunction

  // Next value of the burst counter.
  function automatic int unsigned burst_next(input int unsigned run,
                                             input logic acc,
                                             input logic simple);
    return (acc && simple) ? run + 1 : 0;
  endfunction
endpackage

// File: rtl/fpi_burst_ctr.sv
module fpi_burst_ctr #(
  parameter int unsigned BURST_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic acc_simple,
  output logic at_limit
);
  import fpi_pkg::*;
  localparam int unsigned RW = $clog2(BURST_LEN + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= RW'(burst_next(int'(run_q), acc, acc_simple));
  end

  assign at_limit = (run_q == RW'(BURST_LEN));
endmodule

// File: rtl/fpi_div_timer.sv
module fpi_div_timer #(
  parameter int unsigned DIV_CYCLES = 32,
  parameter int unsigned TAG_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  output logic             blocking,
  output logic             finish,
  output logic [TAG_W-1:0] fin_tag
);
  localparam int unsigned CW = $clog2(DIV_CYCLES + 1);

  logic [CW-1:0]    cnt_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(DIV_CYCLES);
      tag_q <= start_tag;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign blocking = (cnt_q > CW'(1));
  assign finish   = (cnt_q == CW'(1));
  assign fin_tag  = tag_q;
endmodule

// File: rtl/fpi_stage_pipe.sv
module fpi_stage_pipe #(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_dp,
  input  logic [TAG_W-1:0] load_tag,
  output logic             s1_open,
  output logic             all_empty,
  output logic             mid_hold,
  output logic             out_v,
  output logic [TAG_W-1:0] out_tag
);
  logic             s1_v, s1_dp, s2_v, s2_dp, s2_late, s3_v;
  logic [TAG_W-1:0] s1_tag, s2_tag, s3_tag;
  logic             s2_moves;

  assign mid_hold  = s2_v && s2_dp && !s2_late;
  assign s2_moves  = !mid_hold;
  assign s1_open   = !s1_v || s2_moves;
  assign all_empty = !s1_v && !s2_v && !s3_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_dp <= 1'b0; s1_tag <= '0;
      s2_v <= 1'b0; s2_dp <= 1'b0; s2_tag <= '0; s2_late <= 1'b0;
      s3_v <= 1'b0; s3_tag <= '0;
    end else begin
      s3_v   <= s2_v && s2_moves;
      s3_tag <= s2_tag;
      if (s2_moves) begin
        s2_v    <= s1_v;
        s2_dp   <= s1_dp;
        s2_tag  <= s1_tag;
        s2_late <= 1'b0;
      end else begin
        s2_late <= 1'b1;
      end
      if (s1_open) begin
        s1_v   <= load;
        s1_dp  <= load_dp;
        s1_tag <= load_tag;
      end
    end
  end

  assign out_v   = s3_v;
  assign out_tag = s3_tag;
endmodule

// File: rtl/fp_issue_ctrl.sv
module fp_issue_ctrl #(
  parameter int unsigned TAG_W      = 6,
  parameter int unsigned BURST_LEN  = 3,
  parameter int unsigned DIV_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_ready,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag
);
  import fpi_pkg::*;

  logic             burst_limit, div_blocking, div_finish, pipe_empty;
  logic             s1_open, s2_hold, pipe_out_v, accept;
  logic [TAG_W-1:0] pipe_out_tag, div_tag;

  assign in_ready = !div_blocking && !burst_limit && s1_open &&
                    (!kind_is_div(in_kind) || pipe_empty);
  assign accept   = in_valid && in_ready;

  fpi_burst_ctr #(.BURST_LEN(BURST_LEN)) burst_i (
    .clk(clk), .rst_n(rst_n), .acc(accept),
    .acc_simple(kind_in_burst(in_kind)), .at_limit(burst_limit)
  );

  fpi_div_timer #(.DIV_CYCLES(DIV_CYCLES), .TAG_W(TAG_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(accept && kind_is_div(in_kind)),
    .start_tag(in_tag), .blocking(div_blocking), .finish(div_finish),
    .fin_tag(div_tag)
  );

  fpi_stage_pipe #(.TAG_W(TAG_W)) pipe_i (
    .clk(clk), .rst_n(rst_n), .load(accept && !kind_is_div(in_kind)),
    .load_dp(kind_is_dp(in_kind)), .load_tag(in_tag), .s1_open(s1_open),
    .all_empty(pipe_empty), .mid_hold(s2_hold), .out_v(pipe_out_v),
    .out_tag(pipe_out_tag)
  );

  assign done_valid = pipe_out_v || div_finish;
  assign done_tag   = div_finish ? div_tag : pipe_out_tag;
endmodule

// File: rtl/fp_issue_ctrl_chk.sv
module fp_issue_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_kind,
  input logic       done_valid,
  input logic       burst_limit,
  input logic       div_blocking,
  input logic       pipe_empty,
  input logic       s2_hold
);
  import fpi_pkg::*;
  logic div_acc;
  assign div_acc = in_valid && in_ready && (in_kind == KIND_DIV);

  assert_bubble_after_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_limit |-> !in_ready);
  assert_div_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_acc |-> pipe_empty);
  assert_div_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_blocking |-> !in_ready);
  assert_div_start_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_acc |=> !done_valid);
  assert_mid_hold_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_hold |=> !done_valid);
endmodule

bind fp_issue_ctrl fp_issue_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .done_valid(done_valid), .burst_limit(burst_limit),
  .div_blocking(div_blocking), .pipe_empty(pipe_empty), .s2_hold(s2_hold)
);

// File: tb/fp_issue_ctrl_tb.sv
module fp_issue_ctrl_tb_top;
  localparam int TAG_W = 6;
  localparam int NV    = 18;
  // entry: gap[1:0] kind[1:0] expected wait[5:0] expected latency[5:0]
  localparam logic [15:0] VEC [NV] = '{
    {2'd0,2'b00,6'd0,6'd3}, {2'd0,2'b00,6'd0,6'd3}, {2'd0,2'b00,6'd0,6'd3},
    {2'd0,2'b00,6'd1,6'd3}, {2'd1,2'b00,6'd0,6'd3}, {2'd0,2'b00,6'd0,6'd3},
    {2'd1,2'b11,6'd0,6'd3}, {2'd0,2'b00,6'd0,6'd3}, {2'd0,2'b00,6'd0,6'd3},
    {2'd0,2'b00,6'd1,6'd3}, {2'd0,2'b01,6'd0,6'd4}, {2'd0,2'b01,6'd0,6'd5},
    {2'd0,2'b01,6'd1,6'd5}, {2'd0,2'b00,6'd1,6'd4}, {2'd0,2'b10,6'd4,6'd32},
    {2'd0,2'b00,6'd31,6'd3}, {2'd0,2'b10,6'd3,6'd32}, {2'd0,2'b00,6'd31,6'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] in_kind = 2'b00;
  logic [TAG_W-1:0] in_tag = '0, done_tag;
  logic in_ready, done_valid;
  int checks = 0, failures = 0, cyc = 0, n_acc = 0, n_done = 0;
  int acc_cyc [64];
  int exp_lat [64];
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_issue_ctrl #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_tag(in_tag), .in_ready(in_ready), .done_valid(done_valid),
    .done_tag(done_tag)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Completion monitor: R2/R3/R6/R8 order, tag and latency
  always @(negedge clk) begin
    #1;
    if (rst_n && done_valid && !finished) begin
      check(n_done < n_acc, "R3 unexpected completion", n_done, n_acc);
      if (n_done < n_acc) begin
        check(int'(done_tag) == n_done, "R3 tag order", int'(done_tag), n_done);
        check(cyc - acc_cyc[n_done] == exp_lat[n_done], "R2/R6/R8 latency",
              cyc - acc_cyc[n_done], exp_lat[n_done]);
      end
      n_done++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 3000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 3000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(done_valid == 1'b0, "R1 done after reset", done_valid, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      int w;
      repeat (int'(VEC[i][15:14])) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_kind  = VEC[i][13:12];
      in_tag   = TAG_W'(i);
      w = 0;
      forever begin
        #1;
        if (in_ready) break;
        w++;
        @(negedge clk);
      end
      acc_cyc[i] = cyc;
      exp_lat[i] = int'(VEC[i][5:0]);
      n_acc++;
      // R4 bubble, R5 restart, R6 hold stalls, R7/R8 divide waits
      check(w == int'(VEC[i][11:6]), "R4/R5/R6/R7/R8 wait cycles", w, int'(VEC[i][11:6]));
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    // R9: nothing more completes while idle
    check(n_done == NV, "R9 completion count", n_done, NV);

    // R7: readiness depends on the kind while a stage is occupied
    in_valid = 1'b1; in_kind = 2'b00; in_tag = TAG_W'(NV);
    #1;
    acc_cyc[NV] = cyc; exp_lat[NV] = 3; n_acc++;
    @(negedge clk);
    in_valid = 1'b0; in_kind = 2'b10;
    #1;
    check(in_ready == 1'b0, "R7 divide blocked by busy stage", in_ready, 0);
    in_kind = 2'b00;
    #1;
    check(in_ready == 1'b1, "R7 simple still admitted", in_ready, 1);
    repeat (6) @(negedge clk);
    check(n_done == NV + 1, "R9 no accept without valid", n_done, NV + 1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule